// File: doc/BRIEF.md
# Cascaded Two-Stage Priority Interrupt Controller

This block joins two eight-input priority interrupt controllers: a primary unit and a secondary unit. The secondary unit's interrupt output drives every primary input that software marks as linked. Each unit has a two-register window. Software programs a unit with a short command sequence, masks inputs, selects which status register a read returns, and retires serviced interrupts with specific end-of-interrupt commands.

The processor takes an interrupt with a one-cycle acknowledge pulse. One cycle later the block presents the 8-bit vector of the winning request. When the winner is a linked primary input, the vector comes from the secondary unit. If no request remains eligible at the moment of the acknowledge, the block returns the level-7 vector of the unit that was asked. No in-service bit is set in that unit.

Priority is fixed, with input 0 highest. A request waits while any in-service bit at its own level or higher is set.

Top module: `irq_cascade_pair`

## Requirements
- R1: A write to a unit's command register (address bit 0 = 0) with data bit 4 set clears that unit's mask, request and in-service registers. The next writes to its data register (address bit 0 = 1) then load three values in turn: the vector base, the link word and the mode word. The mode word is expected only if bit 0 of the starting word was 1. After that, data-register writes load the mask.
- R2: A granted vector is the base's bits 7:3 with the input number in bits 2:0. With base 0x20, the primary yields 0x20-0x27. With base 0x28, the secondary yields 0x28-0x2F.
- R3: Outside the command sequence, a data-register write loads the mask and a data-register read returns it. A mask bit of 1 keeps that input from raising int_out and from being granted.
- R4: A command write of 0x0B makes later command-register reads return the in-service register. A write of 0x0A makes them return the request register, which is also the selection after reset or after the start word.
- R5: The priority order is fixed, input 0 first. A request is held off while an in-service bit at an equal or higher level is set. A higher-priority request still raises int_out over a lower one that is in service.
- R6: An ordinary input is latched on its rising edge and holds only while the line stays high. A line that stays high after its acknowledge does not request again until it falls and rises again.
- R7: An acknowledge pulse raises ack_valid in the next cycle with the vector on ack_vec. In the same edge it sets the in-service bit of the granted input and clears that input's request bit.
- R8: In the primary, bit n of the link word marks input n as fed by the secondary's interrupt output. The secondary takes bits 2:0 of its link word as its identity. A granted linked input sets the in-service bit in both units and returns the secondary's vector.
- R9: A command write whose bits 7:5 are 011 clears in-service bit n, where n is data bits 2:0. A secondary interrupt is retired by that command to the secondary and then 0x62 to the primary. Until the second command, the primary's in-service bit 2 stays set.
- R10: An acknowledge with no eligible request returns base+7 from the unit asked and sets no in-service bit in that unit. This gives 0x27 when a primary request has vanished, and 0x2F when a secondary request vanishes after the primary latched it.
- R11: Reset clears all registers, leaves int_out and ack_valid low, and selects the request register for command reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines; bits 7:0 to the primary, bits 15:8 to the secondary |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Bit 1 selects the unit (0 primary, 1 secondary); bit 0 selects command (0) or data (1) register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge pulse |
| ack_valid | output | 1 | Vector valid, one cycle after ack |
| ack_vec | output | 8 | Acknowledged vector |

## Verification
The bench builds the block with its default eight lines per unit. Software writes the link word 0x04 to the primary and identity 2 to the secondary, the usual topology. Because linking is programmed rather than fixed, one build reaches direct primary interrupts, cascaded ones, and the two spurious paths (a vanished primary line and a secondary line that drops after the primary latched it). Re-running the start word with and without the mode-word flag reaches both lengths of the programming sequence.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int LINES  = 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int DATA_W = 8;
    localparam int BASE_W = DATA_W - IDX_W;

    typedef enum logic [1:0] {
        PH_RUN,
        PH_BASE,
        PH_LINK,
        PH_MODE
    } cfg_phase_e;

    typedef struct packed {
        cfg_phase_e          phase;
        logic [BASE_W-1:0]   base;
        logic [LINES-1:0]    link;
        logic                want_mode;
        logic                show_isr;
        logic [LINES-1:0]    imr;
        logic [LINES-1:0]    irr;
        logic [LINES-1:0]    isr;
        logic [LINES-1:0]    prev;
    } ctl_state_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] vec;
    } ack_out_t;
endpackage

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [LINES-1:0] req,
    input  logic [LINES-1:0] isr,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [LINES-1:0] blocked;
    logic [LINES-1:0] elig;

    // a level is held off by any in-service bit at or above its priority
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_blk
            assign blocked[g] = |isr[g:0];
        end
    endgenerate

    assign elig = req & ~blocked;
    assign any  = |elig;

    always_comb begin
        idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
    import irqc_pkg::*;
#(
    parameter bit IS_SLAVE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  req_in,
    input  logic              link_in,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_in,
    output logic [DATA_W-1:0] rdata,
    output logic              int_o,
    output logic              grant_link,
    output logic [IDX_W-1:0]  grant_idx,
    output logic [DATA_W-1:0] vec_o,
    output logic [IDX_W-1:0]  link_id,
    output logic [LINES-1:0]  isr_o,
    output logic [LINES-1:0]  irr_o,
    output logic [LINES-1:0]  imr_o
);
    ctl_state_t q, d;

    logic [LINES-1:0] lvl_mask;
    logic [LINES-1:0] eff_req;
    logic [LINES-1:0] rise;
    logic             prio_any;
    logic             running;
    logic             any;

    // only the primary treats linked inputs as level lines from the secondary
    generate
        if (IS_SLAVE) begin : g_sec
            assign lvl_mask = '0;
        end else begin : g_pri
            assign lvl_mask = q.link;
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            eff_req[i] = lvl_mask[i] ? link_in : req_in[i];
        end
    end

    assign rise    = eff_req & ~q.prev;
    assign running = (q.phase == PH_RUN);

    irqc_prio u_prio (
        .req (q.irr & ~q.imr),
        .isr (q.isr),
        .any (prio_any),
        .idx (grant_idx)
    );

    assign any        = prio_any & running;
    assign int_o      = any;
    assign grant_link = any & lvl_mask[grant_idx];
    assign vec_o      = {q.base, any ? grant_idx : IDX_W'(LINES - 1)};
    assign link_id    = q.link[IDX_W-1:0];
    assign rdata      = reg_sel ? q.imr : (q.show_isr ? q.isr : q.irr);
    assign isr_o      = q.isr;
    assign irr_o      = q.irr;
    assign imr_o      = q.imr;

    always_comb begin
        d      = q;
        d.prev = eff_req;
        d.irr  = (((q.irr | rise) & eff_req) & ~lvl_mask) | (eff_req & lvl_mask);

        if (ack_in && any) begin
            d.isr[grant_idx] = 1'b1;
            if (!lvl_mask[grant_idx]) d.irr[grant_idx] = 1'b0;
        end

        if (wr_en) begin
            if (!reg_sel) begin
                if (wdata[4]) begin
                    d.phase     = PH_BASE;
                    d.want_mode = wdata[0];
                    d.imr       = '0;
                    d.irr       = '0;
                    d.isr       = '0;
                    d.show_isr  = 1'b0;
                end else if (wdata[3]) begin
                    if (wdata[1]) d.show_isr = wdata[0];
                end else if (wdata[7:5] == 3'b011) begin
                    d.isr[wdata[IDX_W-1:0]] = 1'b0;
                end
            end else begin
                unique case (q.phase)
                    PH_BASE: begin
                        d.base  = wdata[DATA_W-1:IDX_W];
                        d.phase = PH_LINK;
                    end
                    PH_LINK: begin
                        d.link  = wdata;
                        d.phase = q.want_mode ? PH_MODE : PH_RUN;
                    end
                    PH_MODE: d.phase = PH_RUN;
                    default: d.imr   = wdata;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase     <= PH_RUN;
            q.base      <= '0;
            q.link      <= '0;
            q.want_mode <= 1'b0;
            q.show_isr  <= 1'b0;
            q.imr       <= '0;
            q.irr       <= '0;
            q.isr       <= '0;
            q.prev      <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/irq_cascade_pair.sv
module irq_cascade_pair
    import irqc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*LINES-1:0]    irq_in,
    input  logic                  bus_wr,
    input  logic [1:0]            bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  int_out,
    input  logic                  ack,
    output logic                  ack_valid,
    output logic [DATA_W-1:0]     ack_vec
);
    logic [DATA_W-1:0] m_rdata, s_rdata, m_vec, s_vec;
    logic              m_int, s_int, m_glink, s_glink;
    logic [IDX_W-1:0]  m_idx, s_idx, m_id, s_id;
    logic [LINES-1:0]  m_isr, m_irr, m_imr, s_isr, s_irr, s_imr;
    logic              s_ack;
    ack_out_t          out_q, out_d;

    irqc_unit #(.IS_SLAVE(1'b0)) u_pri (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_in     (irq_in[LINES-1:0]),
        .link_in    (s_int),
        .wr_en      (bus_wr & ~bus_addr[1]),
        .reg_sel    (bus_addr[0]),
        .wdata      (bus_wdata),
        .ack_in     (ack),
        .rdata      (m_rdata),
        .int_o      (m_int),
        .grant_link (m_glink),
        .grant_idx  (m_idx),
        .vec_o      (m_vec),
        .link_id    (m_id),
        .isr_o      (m_isr),
        .irr_o      (m_irr),
        .imr_o      (m_imr)
    );

    // secondary answers only when the primary grants the input matching its identity
    assign s_ack = ack & m_glink & (m_idx == s_id);

    irqc_unit #(.IS_SLAVE(1'b1)) u_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_in     (irq_in[2*LINES-1:LINES]),
        .link_in    (1'b0),
        .wr_en      (bus_wr & bus_addr[1]),
        .reg_sel    (bus_addr[0]),
        .wdata      (bus_wdata),
        .ack_in     (s_ack),
        .rdata      (s_rdata),
        .int_o      (s_int),
        .grant_link (s_glink),
        .grant_idx  (s_idx),
        .vec_o      (s_vec),
        .link_id    (s_id),
        .isr_o      (s_isr),
        .irr_o      (s_irr),
        .imr_o      (s_imr)
    );

    assign bus_rdata = bus_addr[1] ? s_rdata : m_rdata;
    assign int_out   = m_int;

    always_comb begin
        out_d.valid = ack;
        out_d.vec   = out_q.vec;
        if (ack) out_d.vec = m_glink ? s_vec : m_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ack_valid = out_q.valid;
    assign ack_vec   = out_q.vec;

    logic unused_ok;
    assign unused_ok = ^{m_id, s_glink, s_idx, s_irr, s_imr};
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              ack,
    input logic              ack_valid,
    input logic [DATA_W-1:0] ack_vec,
    input logic              int_out,
    input logic [LINES-1:0]  m_isr,
    input logic [LINES-1:0]  m_irr,
    input logic [LINES-1:0]  m_imr
);
    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'b00 && bus_wdata[4])
        |=> (m_isr == '0 && m_irr == '0 && m_imr == '0));

    assert_int_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (|(m_irr & ~m_imr)));

    assert_ack_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ack_valid);

    assert_no_stray_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !ack_valid);

    assert_grant_sets_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !bus_wr)
        |=> ($countones(m_isr) == $countones($past(m_isr)) + 1));

    assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'b00 && bus_wdata[7:3] == 5'b01100)
        |=> !m_isr[$past(bus_wdata[IDX_W-1:0])]);

    assert_spurious_level7_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out) |=> (ack_vec[IDX_W-1:0] == IDX_W'(LINES - 1)));
endmodule

bind irq_cascade_pair irqc_checker u_chk (.*);

// File: tb/sim_irq_cascade_pair.sv
module sim_irq_cascade_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        int_out;
    logic        ack = 1'b0;
    logic        ack_valid;
    logic [7:0]  ack_vec;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    irq_cascade_pair u0 (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic do_ack(output logic [7:0] v, output logic val);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        v = ack_vec; val = ack_valid;
    endtask

    task automatic read_isr(input logic [1:0] unit_cmd, output logic [7:0] v);
        wr(unit_cmd, 8'h0B);
        rd(unit_cmd, v);
        wr(unit_cmd, 8'h0A);
    endtask

    task automatic setup_pair();
        wr(2'b00, 8'h11); wr(2'b01, 8'h20); wr(2'b01, 8'h04); wr(2'b01, 8'h01);
        wr(2'b10, 8'h11); wr(2'b11, 8'h28); wr(2'b11, 8'h02); wr(2'b11, 8'h01);
        wr(2'b01, 8'h00); wr(2'b11, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R11 int_out low", {7'd0, int_out}, 8'h00);
        chk("R11 ack_valid low", {7'd0, ack_valid}, 8'h00);
        rd(2'b00, v); chk("R11 request reg clear", v, 8'h00);
        rd(2'b01, v); chk("R11 mask clear", v, 8'h00);
    endtask

    task automatic t_init();
        logic [7:0] v;
        setup_pair();
        wr(2'b01, 8'hFF); rd(2'b01, v); chk("R3 mask readback", v, 8'hFF);
        wr(2'b00, 8'h11); rd(2'b01, v); chk("R1 start clears mask", v, 8'h00);
        wr(2'b01, 8'h20); wr(2'b01, 8'h04); wr(2'b01, 8'h01);
        wr(2'b01, 8'h5A); rd(2'b01, v); chk("R1 fourth write loads mask", v, 8'h5A);
        wr(2'b00, 8'h10); wr(2'b01, 8'h20); wr(2'b01, 8'h04);
        wr(2'b01, 8'h3C); rd(2'b01, v); chk("R1 no mode word, third write is mask", v, 8'h3C);
        setup_pair();
    endtask

    task automatic t_mask();
        logic [7:0] v; logic val;
        wr(2'b01, 8'h08);
        @(negedge clk); irq_in[3] = 1'b1; idle(2);
        chk("R3 masked input no int", {7'd0, int_out}, 8'h00);
        rd(2'b00, v); chk("R4 request reg shows bit3", v, 8'h08);
        wr(2'b01, 8'h00); idle(1);
        chk("R3 unmasked raises int", {7'd0, int_out}, 8'h01);
        do_ack(v, val);
        chk("R7 ack_valid", {7'd0, val}, 8'h01);
        chk("R2 vector 0x23", v, 8'h23);
        read_isr(2'b00, v); chk("R4 R7 in-service bit3", v, 8'h08);
        rd(2'b00, v); chk("R7 request bit cleared", v, 8'h00);
        wr(2'b00, 8'h63);
        read_isr(2'b00, v); chk("R9 EOI clears bit3", v, 8'h00);
        @(negedge clk); irq_in[3] = 1'b0; idle(2);
    endtask

    task automatic t_prio();
        logic [7:0] v; logic val;
        @(negedge clk); irq_in[5] = 1'b1; irq_in[1] = 1'b1; idle(2);
        do_ack(v, val); chk("R5 input 1 wins", v, 8'h21);
        idle(1); chk("R5 lower blocked by in-service", {7'd0, int_out}, 8'h00);
        wr(2'b00, 8'h61); idle(1);
        chk("R5 lower runs after EOI", {7'd0, int_out}, 8'h01);
        do_ack(v, val); chk("R2 vector 0x25", v, 8'h25);
        @(negedge clk); irq_in[0] = 1'b1; idle(2);
        chk("R5 higher preempts", {7'd0, int_out}, 8'h01);
        do_ack(v, val); chk("R5 input 0 vector", v, 8'h20);
        read_isr(2'b00, v); chk("R5 nested in-service", v, 8'h21);
        wr(2'b00, 8'h60); wr(2'b00, 8'h65);
        @(negedge clk); irq_in[0] = 1'b0; irq_in[1] = 1'b0; irq_in[5] = 1'b0; idle(2);
    endtask

    task automatic t_edge();
        logic [7:0] v; logic val;
        @(negedge clk); irq_in[4] = 1'b1; idle(2);
        do_ack(v, val); chk("R6 first edge vector", v, 8'h24);
        wr(2'b00, 8'h64); idle(2);
        chk("R6 held line no re-request", {7'd0, int_out}, 8'h00);
        @(negedge clk); irq_in[4] = 1'b0; idle(1);
        @(negedge clk); irq_in[4] = 1'b1; idle(2);
        chk("R6 new edge requests", {7'd0, int_out}, 8'h01);
        do_ack(v, val); chk("R6 second edge vector", v, 8'h24);
        wr(2'b00, 8'h64);
        @(negedge clk); irq_in[4] = 1'b0; idle(2);
        @(negedge clk); irq_in[6] = 1'b1; idle(2);
        chk("R6 request raised", {7'd0, int_out}, 8'h01);
        @(negedge clk); irq_in[6] = 1'b0;
        do_ack(v, val); chk("R10 vanished request gives 0x27", v, 8'h27);
        read_isr(2'b00, v); chk("R10 no in-service set", v, 8'h00);
    endtask

    task automatic t_cascade();
        logic [7:0] v; logic val;
        @(negedge clk); irq_in[9] = 1'b1; idle(3);
        chk("R8 secondary raises int", {7'd0, int_out}, 8'h01);
        do_ack(v, val); chk("R8 R2 secondary vector 0x29", v, 8'h29);
        read_isr(2'b00, v); chk("R8 primary in-service bit2", v, 8'h04);
        read_isr(2'b10, v); chk("R8 secondary in-service bit1", v, 8'h02);
        wr(2'b10, 8'h61);
        read_isr(2'b10, v); chk("R9 secondary EOI", v, 8'h00);
        read_isr(2'b00, v); chk("R9 primary still in service", v, 8'h04);
        wr(2'b00, 8'h62);
        read_isr(2'b00, v); chk("R9 primary EOI 0x62", v, 8'h00);
        @(negedge clk); irq_in[9] = 1'b0; idle(3);
        @(negedge clk); irq_in[12] = 1'b1; idle(3);
        @(negedge clk); irq_in[12] = 1'b0;
        do_ack(v, val); chk("R10 vanished secondary gives 0x2F", v, 8'h2F);
        read_isr(2'b10, v); chk("R10 secondary no in-service", v, 8'h00);
        wr(2'b00, 8'h62);
        read_isr(2'b00, v); chk("R9 primary cleared after spurious", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_mask();
        t_prio();
        t_edge();
        t_cascade();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule